// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block runs erase and buffered-program operations on a parallel NOR flash that sits behind a memory window on a simple 16-bit bus. A host gives it one command at a time. The command is either a sector erase, or a program of N words that the host has already loaded into the block's internal word buffer. The block then drives the bus cycles the flash needs, in the order it needs them. Each command begins with two unlock writes to fixed unlock addresses. Command codes go to the window base. Program data goes to consecutive halfword addresses.

After the last write of a command, the block polls the flash with reads. An erase counts as finished when the window base reads back all ones. A program counts as finished when bit 7 of the last programmed word matches bit 7 of the data written there. A per-command poll limit caps the number of unsuccessful reads; reaching it ends the command with an error. Every bus cycle uses a valid/ready handshake, and read data comes back with its own response strobe.

Top module: `nor_cmd_seq`

## Requirements
- R1: An erase command (cmd_op = 0) issues exactly six writes, in this order: 0x00AA to the first unlock address, 0x0055 to the second unlock address, 0x0080 to the first, 0x00AA to the first, 0x0055 to the second, then 0x0030 to the window base.
- R2: After an erase, the block reads the window base repeatedly. It finishes with done only when a read returns 0xFFFF.
- R3: A program command (cmd_op = 1) of N words issues exactly N+5 writes, in this order: 0x00AA to the first unlock address, 0x0055 to the second, 0x0025 to the window base, N-1 to the window base, buffer words 0 to N-1 to the data addresses, then 0x0029 to the window base.
- R4: The data address of word i is (window base OR (cmd_offset AND 0x3FFFF)) + 2·i. Bits of cmd_offset above bit 17 have no effect.
- R5: After a program, every poll reads the address of word N-1. The block finishes with done once bit 7 of the read data equals bit 7 of buffer word N-1.
- R6: A program command with a count of 0 or above MAX_WORDS is rejected. It produces an error pulse in the cycle after it is presented, produces no bus cycle, and never raises busy.
- R7: If a poll read does not show completion and it is read number max(poll_limit, 1) of the command, the block raises error instead of done and stops polling.
- R8: While bus_valid is high and bus_ready is low, bus_valid, bus_write, bus_addr and bus_wdata hold their values into the next cycle.
- R9: busy rises in the cycle after a command is accepted and falls together with the done or error pulse. A cmd_valid seen while busy is ignored, and no bus cycle happens while busy is low.
- R10: done and error are single-cycle pulses and are never high together. After a polled command, the pulse appears one cycle after the response that ends the command.
- R11: During and right after reset, busy, done, error and bus_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken while idle |
| cmd_op | input | 1 | 0 = sector erase, 1 = buffered program |
| cmd_count | input | CNT_W | Number of words to program |
| cmd_offset | input | ADDR_W | Byte offset of the first word; the low 18 bits are used |
| poll_limit | input | TMO_W | Maximum number of unsuccessful completion reads |
| buf_we | input | 1 | Word buffer write enable |
| buf_idx | input | IDX_W | Word buffer write index |
| buf_data | input | 16 | Word buffer write data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: command completed |
| error | output | 1 | One-cycle pulse: command rejected or timed out |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_ready | input | 1 | Bus accepts the current request |
| rsp_valid | input | 1 | Read data strobe |
| rsp_data | input | 16 | Read data |

## Verification
The bench drives a command for one cycle and expects the following:
- busy is high at the next falling edge.
- For a rejected command, error is high at that same falling edge instead.
- The done or error of a polled command is high exactly one falling edge after the edge at which the final response strobe was seen. The bench records that response cycle and compares against it, so it never simply waits for a flag.

The behavioural responder inserts ready stalls and returns read data one cycle after each read handshake. It logs every write and every read address. Whole sequences, read counts and quiet periods are then compared against lists computed from the requirements.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_POLL_REQ,
        ST_POLL_WAIT
    } seq_state_t;

    typedef enum logic {
        OP_ERASE   = 1'b0,
        OP_PROGRAM = 1'b1
    } seq_op_t;

    typedef enum logic [1:0] {
        TGT_UNLK_A,
        TGT_UNLK_B,
        TGT_BASE,
        TGT_DATA
    } tgt_t;

    typedef enum logic [1:0] {
        SRC_CONST,
        SRC_COUNT,
        SRC_BUFFER
    } src_t;

    typedef struct packed {
        tgt_t        tgt;
        src_t        src;
        logic [15:0] konst;
        logic        last;
    } step_t;

    localparam logic [15:0] CODE_UNLK_1   = 16'h00AA;
    localparam logic [15:0] CODE_UNLK_2   = 16'h0055;
    localparam logic [15:0] CODE_ERS_ARM  = 16'h0080;
    localparam logic [15:0] CODE_ERS_GO   = 16'h0030;
    localparam logic [15:0] CODE_PGM_LOAD = 16'h0025;
    localparam logic [15:0] CODE_PGM_GO   = 16'h0029;
    localparam logic [15:0] ERASED_WORD   = 16'hFFFF;

    // Describes write number 'step' of a command.
    function automatic step_t plan_step(seq_op_t op, int step, int nwords);
        step_t s;
        s.tgt   = TGT_BASE;
        s.src   = SRC_CONST;
        s.konst = 16'h0000;
        s.last  = 1'b0;
        if (step == 0) begin
            s.tgt = TGT_UNLK_A; s.konst = CODE_UNLK_1;
        end else if (step == 1) begin
            s.tgt = TGT_UNLK_B; s.konst = CODE_UNLK_2;
        end else if (op == OP_ERASE) begin
            if (step == 2) begin
                s.tgt = TGT_UNLK_A; s.konst = CODE_ERS_ARM;
            end else if (step == 3) begin
                s.tgt = TGT_UNLK_A; s.konst = CODE_UNLK_1;
            end else if (step == 4) begin
                s.tgt = TGT_UNLK_B; s.konst = CODE_UNLK_2;
            end else begin
                s.konst = CODE_ERS_GO; s.last = 1'b1;
            end
        end else begin
            if (step == 2) begin
                s.konst = CODE_PGM_LOAD;
            end else if (step == 3) begin
                s.src = SRC_COUNT;
            end else if (step < 4 + nwords) begin
                s.tgt = TGT_DATA; s.src = SRC_BUFFER;
            end else begin
                s.konst = CODE_PGM_GO; s.last = 1'b1;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/nfs_word_buf.sv
module nfs_word_buf #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [15:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [15:0]      rdata
);
    logic [15:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [15:0] word_q;
        always_ff @(posedge clk) begin
            if (we && widx == IDX_W'(g)) word_q <= wdata;
        end
        assign words[g] = word_q;
    end

    always_comb begin
        rdata = 16'h0000;
        for (int i = 0; i < DEPTH; i++) begin
            if (ridx == IDX_W'(i)) rdata = words[i];
        end
    end
endmodule

// File: rtl/nfs_poll_timer.sv
module nfs_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    input  logic [TMO_W-1:0] limit,
    output logic             last_try
);
    logic [TMO_W-1:0] tries_q;

    always_ff @(posedge clk) begin
        if (rst || clear) tries_q <= '0;
        else if (bump)    tries_q <= tries_q + 1'b1;
    end

    // The read in flight is try number tries_q + 1.
    assign last_try = ({1'b0, tries_q} + (TMO_W+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nfs_pkg::*;
#(
    parameter int              ADDR_W        = 20,
    parameter int              MAX_WORDS     = 16,
    parameter int              CNT_W         = 8,
    parameter int              TMO_W         = 16,
    parameter int              OFS_W         = 18,
    parameter logic [ADDR_W-1:0] UNLOCK_A_ADDR = 20'h00408,
    parameter logic [ADDR_W-1:0] UNLOCK_B_ADDR = 20'h00400,
    parameter logic [ADDR_W-1:0] WINDOW_BASE   = 20'h60000,
    localparam int             IDX_W         = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [ADDR_W-1:0] cmd_offset,
    input  logic [TMO_W-1:0]  poll_limit,
    input  logic              buf_we,
    input  logic [IDX_W-1:0]  buf_idx,
    input  logic [15:0]       buf_data,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic              bus_ready,
    input  logic              rsp_valid,
    input  logic [15:0]       rsp_data
);
    localparam int STEP_W = $clog2(MAX_WORDS + 6);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << OFS_W) - 64'd1);

    seq_state_t        state_q;
    seq_op_t           op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] start_q;
    logic [STEP_W-1:0] step_q;
    logic [TMO_W-1:0]  limit_q;
    logic              done_q, err_q;

    step_t             cur;
    logic [IDX_W-1:0]  rd_idx;
    logic [15:0]       buf_rdata;
    logic [ADDR_W-1:0] word_addr;
    logic              poll_ok, last_try, accept, bad_len, fail_bump;

    assign accept  = (state_q == ST_IDLE) && cmd_valid;
    assign bad_len = (cmd_op == OP_PROGRAM) &&
                     (cmd_count == '0 || cmd_count > CNT_W'(MAX_WORDS));

    always_comb cur = plan_step(op_q, int'(step_q), int'(cnt_q));

    // The buffer index is the current word while writing and the last word while polling.
    always_comb begin
        if (state_q == ST_WRITE) rd_idx = IDX_W'(step_q - STEP_W'(4));
        else                     rd_idx = IDX_W'(cnt_q - 1'b1);
    end
    assign word_addr = start_q + (ADDR_W'(rd_idx) << 1);

    nfs_word_buf #(.DEPTH(MAX_WORDS), .IDX_W(IDX_W)) wbuf_i (
        .clk  (clk),
        .we   (buf_we),
        .widx (buf_idx),
        .wdata(buf_data),
        .ridx (rd_idx),
        .rdata(buf_rdata)
    );

    assign poll_ok   = (op_q == OP_ERASE) ? (rsp_data == ERASED_WORD)
                                          : (rsp_data[7] == buf_rdata[7]);
    assign fail_bump = (state_q == ST_POLL_WAIT) && rsp_valid && !poll_ok && !last_try;

    nfs_poll_timer #(.TMO_W(TMO_W)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .bump    (fail_bump),
        .limit   (limit_q),
        .last_try(last_try)
    );

    // Bus request outputs
    assign bus_valid = (state_q == ST_WRITE) || (state_q == ST_POLL_REQ);
    assign bus_write = (state_q == ST_WRITE);

    always_comb begin
        if (state_q != ST_WRITE) begin
            bus_addr = (op_q == OP_ERASE) ? WINDOW_BASE : word_addr;
        end else begin
            case (cur.tgt)
                TGT_UNLK_A: bus_addr = UNLOCK_A_ADDR;
                TGT_UNLK_B: bus_addr = UNLOCK_B_ADDR;
                TGT_DATA:   bus_addr = word_addr;
                default:    bus_addr = WINDOW_BASE;
            endcase
        end
        case (cur.src)
            SRC_COUNT:  bus_wdata = 16'(cnt_q - 1'b1);
            SRC_BUFFER: bus_wdata = buf_rdata;
            default:    bus_wdata = cur.konst;
        endcase
    end

    // Sequencing state machine
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_ERASE;
            cnt_q   <= '0;
            start_q <= '0;
            step_q  <= '0;
            limit_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (bad_len) begin
                            err_q <= 1'b1;
                        end else begin
                            op_q    <= seq_op_t'(cmd_op);
                            cnt_q   <= cmd_count;
                            start_q <= WINDOW_BASE | (cmd_offset & OFS_MASK);
                            limit_q <= poll_limit;
                            step_q  <= '0;
                            state_q <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (bus_ready) begin
                        if (cur.last) state_q <= ST_POLL_REQ;
                        else          step_q  <= step_q + 1'b1;
                    end
                end
                ST_POLL_REQ: begin
                    if (bus_ready) state_q <= ST_POLL_WAIT;
                end
                default: begin
                    if (rsp_valid) begin
                        if (poll_ok) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (last_try) begin
                            err_q   <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_POLL_REQ;
                        end
                    end
                end
            endcase
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign done  = done_q;
    assign error = err_q;
endmodule

// File: rtl/nfs_checker.sv
module nfs_checker #(
    parameter int                ADDR_W        = 20,
    parameter logic [ADDR_W-1:0] UNLOCK_A_ADDR = 20'h00408
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_ready,
    input logic              rsp_valid
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_write) &&
                                       $stable(bus_addr) && $stable(bus_wdata))); // R8

    AST_NO_BUS_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_valid); // R9

    AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !busy); // R9

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done && error)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rsp_valid)); // R2

    AST_OPENS_WITH_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (bus_valid && bus_write && bus_addr == UNLOCK_A_ADDR &&
                         bus_wdata == 16'h00AA)); // R1
endmodule

bind nor_cmd_seq nfs_checker #(
    .ADDR_W       (ADDR_W),
    .UNLOCK_A_ADDR(UNLOCK_A_ADDR)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ready(bus_ready),
    .rsp_valid(rsp_valid)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
    localparam logic [19:0] UA = 20'h00408;
    localparam logic [19:0] UB = 20'h00400;
    localparam logic [19:0] WB = 20'h60000;
    localparam int          MAXW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [7:0]  cmd_count = '0;
    logic [19:0] cmd_offset = '0;
    logic [15:0] poll_limit = '0;
    logic        buf_we = 1'b0;
    logic [3:0]  buf_idx = '0;
    logic [15:0] buf_data = '0;
    logic        busy, done, error, bus_valid, bus_write;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_data = '0;

    int vectors = 0;
    int misses  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nor_cmd_seq dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .cmd_offset(cmd_offset), .poll_limit(poll_limit),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
        .busy(busy), .done(done), .error(error),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Behavioural flash responder: stalls ready, answers reads one cycle later, logs all cycles.
    int          tick = 0;
    int          wr_n = 0;
    int          rd_n = 0;
    int          rd_base = 0;
    int          fail_polls = 0;
    logic [15:0] good_word = '0;
    logic [15:0] bad_word = '0;
    logic        pend = 1'b0;
    logic [15:0] pend_data = '0;
    logic [19:0] wlog_a [2048];
    logic [15:0] wlog_d [2048];
    logic [19:0] rlog_a [2048];

    always @(posedge clk) begin
        tick      <= tick + 1;
        bus_ready <= (tick % 4) != 2;
        rsp_valid <= pend;
        rsp_data  <= pend_data;
        pend      <= 1'b0;
        if (!rst && bus_valid && bus_ready) begin
            if (bus_write) begin
                wlog_a[wr_n % 2048] <= bus_addr;
                wlog_d[wr_n % 2048] <= bus_wdata;
                wr_n <= wr_n + 1;
            end else begin
                rlog_a[rd_n % 2048] <= bus_addr;
                pend      <= 1'b1;
                pend_data <= ((rd_n - rd_base) < fail_polls) ? bad_word : good_word;
                rd_n <= rd_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word_pat(input int n, input int i);
        return 16'((n * 16'h1357) ^ (i * 16'h0F1D) ^ (i * i * 5));
    endfunction

    function automatic void exp_write(input bit prog, input int n, input logic [19:0] start,
                                      input int k, output logic [19:0] a, output logic [15:0] d);
        a = WB; d = 16'h0000;
        if (k == 0)      begin a = UA; d = 16'h00AA; end
        else if (k == 1) begin a = UB; d = 16'h0055; end
        else if (!prog) begin
            case (k)
                2: begin a = UA; d = 16'h0080; end
                3: begin a = UA; d = 16'h00AA; end
                4: begin a = UB; d = 16'h0055; end
                default: begin a = WB; d = 16'h0030; end
            endcase
        end else begin
            if (k == 2)          d = 16'h0025;
            else if (k == 3)     d = 16'(n - 1);
            else if (k < 4 + n)  begin a = 20'(start + 20'(2 * (k - 4))); d = word_pat(n, k - 4); end
            else                 d = 16'h0029;
        end
    endfunction

    task automatic run_cmd(input bit prog, input int n, input logic [19:0] off,
                           input int fails, input int lim, input bit inject);
        int wr0, rd0, lim1, exp_reads, exp_w, cyc, rsp_cyc;
        bit exp_err, rejected;
        logic [19:0] start, poll_a, ea;
        logic [15:0] ed;
        if (prog) begin
            for (int i = 0; i < n && i < MAXW; i++) begin
                buf_we = 1'b1; buf_idx = 4'(i); buf_data = word_pat(n, i);
                @(negedge clk);
            end
            buf_we = 1'b0;
        end
        good_word  = prog ? word_pat(n, n - 1) : 16'hFFFF;
        bad_word   = prog ? (good_word ^ 16'h0080) : 16'hFFFE;
        fail_polls = fails;
        rd_base    = rd_n;
        wr0 = wr_n; rd0 = rd_n;
        start  = WB | (off & 20'h3FFFF);
        poll_a = prog ? 20'(start + 20'(2 * (n - 1))) : WB;
        rejected = prog && (n == 0 || n > MAXW);
        cmd_valid = 1'b1; cmd_op = prog; cmd_count = 8'(n);
        cmd_offset = off; poll_limit = 16'(lim);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (rejected) begin
            chk(error == 1'b1 && busy == 1'b0, "R6 reject pulse", {error, busy}, 2);
            repeat (6) @(negedge clk);
            chk(wr_n == wr0 && rd_n == rd0, "R6 no bus cycles", wr_n - wr0 + rd_n - rd0, 0);
            chk(busy == 1'b0, "R6 busy stays low", busy, 0);
            return;
        end
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        cyc = 0; rsp_cyc = -10;
        forever begin
            if (done || error || cyc > 3000) break;
            if (rsp_valid) rsp_cyc = cyc;
            if (inject && cyc == 3) begin cmd_valid = 1'b1; cmd_op = 1'b0; end
            if (inject && cyc == 4) cmd_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0;
        lim1      = (lim == 0) ? 1 : lim;
        exp_err   = fails >= lim1;
        exp_reads = exp_err ? lim1 : fails + 1;
        exp_w     = prog ? n + 5 : 6;
        chk(cyc == rsp_cyc + 1, "R10 pulse one cycle after response", cyc, rsp_cyc + 1);
        if (exp_err) chk(error && !done, "R7 timeout error", {done, error}, 1);
        else if (prog) chk(done && !error, "R5 program done", {done, error}, 2);
        else chk(done && !error, "R2 erase done", {done, error}, 2);
        chk(busy == 1'b0, "R9 busy falls with pulse", busy, 0);
        chk(rd_n - rd0 == exp_reads, prog ? "R5 poll count" : "R2 poll count", rd_n - rd0, exp_reads);
        for (int r = rd0; r < rd_n; r++)
            chk(rlog_a[r % 2048] == poll_a, prog ? "R5 R4 poll address" : "R2 poll address",
                int'(rlog_a[r % 2048]), int'(poll_a));
        chk(wr_n - wr0 == exp_w, prog ? "R3 write count" : "R1 write count", wr_n - wr0, exp_w);
        for (int k = 0; k < exp_w && wr0 + k < wr_n; k++) begin
            exp_write(prog, n, start, k, ea, ed);
            chk(wlog_a[(wr0 + k) % 2048] == ea, prog ? "R3 R4 write address" : "R1 write address",
                int'(wlog_a[(wr0 + k) % 2048]), int'(ea));
            chk(wlog_d[(wr0 + k) % 2048] == ed, prog ? "R3 write data" : "R1 write data",
                int'(wlog_d[(wr0 + k) % 2048]), int'(ed));
        end
        @(negedge clk);
        chk(!done && !error, "R10 single-cycle pulse", {done, error}, 0);
        wr0 = wr_n; rd0 = rd_n;
        repeat (8) @(negedge clk);
        chk(wr_n == wr0 && rd_n == rd0 && !busy, "R9 quiet after end",
            wr_n - wr0 + rd_n - rd0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && !bus_valid, "R11 state in reset",
            {busy, done, error, bus_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !error && !bus_valid, "R11 state after reset",
            {busy, done, error, bus_valid}, 0);

        run_cmd(1'b0, 0, 20'h0, 0, 8, 1'b0);
        run_cmd(1'b0, 0, 20'h0, 1, 8, 1'b0);
        run_cmd(1'b0, 0, 20'h0, 3, 8, 1'b1);
        for (int n = 1; n <= MAXW; n++)
            run_cmd(1'b1, n, 20'(n * 20'h0A5A3), n % 3, 8, n == 4);
        run_cmd(1'b1, 0, 20'h00100, 0, 8, 1'b0);
        run_cmd(1'b1, 17, 20'h00100, 0, 8, 1'b0);
        run_cmd(1'b1, 200, 20'h00100, 0, 8, 1'b0);
        run_cmd(1'b0, 0, 20'h0, 5, 3, 1'b0);
        run_cmd(1'b1, 5, 20'h12345, 9, 0, 1'b0);
        run_cmd(1'b1, 2, 20'hFFFFE, 2, 2, 1'b0);
        run_cmd(1'b1, 3, 20'h3FFF0, 1, 2, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            vectors++;
            misses++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule